// File: doc/BRIEF.md
# Cycle Counter and Compare Timer with Interrupt-Pending Field

This block keeps a 32-bit free-running counter that steps once for every two core clock cycles, together with a 32-bit compare register. When the counter reaches the compare value, a timer interrupt becomes pending. It stays pending until software loads a new compare value.

The block also assembles the 8-bit interrupt-pending field of the cause register. That field holds two software interrupt bits, five hardware interrupt lines and the timer bit. Software can set the two software bits by writing cause. A cause write never clears them.

Software reaches the three registers through a single-cycle register port. Each cycle carries at most one write, chosen by a select code. A combinational read returns the register named by a second select code. The port accepts every access in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. The pending vector goes out on plain wires to whatever logic does masking and priority.

Top module: `tick_compare_unit`

## Requirements
- R1: After reset, the counter and compare registers read zero, both software bits are clear and the timer pending bit is clear.
- R2: With no counter write, the counter holds across one rising edge and increments on the next, so it advances by one every two clock cycles. After reset, the first increment happens on the second rising edge.
- R3: A counter write (wr_sel = 0) loads wr_data on that edge and restarts the half-rate phase. The value holds for one edge and increments on the second edge after the write.
- R4: The counter wraps from 0xFFFFFFFF to 0x00000000.
- R5: A compare write (wr_sel = 1) loads wr_data. The value reads back through rd_sel = 1.
- R6: A compare write clears the timer pending bit (pending bit 7) on its edge. If the counter matches on that same edge, the clear wins.
- R7: The timer pending bit is set on the edge where the counter takes a value equal to compare, whether by advancing or by a load. It stays set until compare is written.
- R8: A cause write (wr_sel = 2) ORs wr_data bit 8 into software bit 0 and wr_data bit 9 into software bit 1. It ignores all other bits. Writing zero clears nothing; only reset clears the software bits.
- R9: Pending bits 6..2 follow hw_irq[4:0] combinationally.
- R10: A cause read (rd_sel = 2) returns the pending vector in bits 15..8, with bit 8 = software 0, bit 9 = software 1, bits 14..10 = hardware and bit 15 = timer. All other bits read zero.
- R11: rd_sel = 3 reads zero, and a write with wr_sel = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare, 2 cause, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| hw_irq | input | 5 | Hardware interrupt levels |
| ip_o | output | 8 | Interrupt-pending vector |

## Verification
The assertions assume rst_n is held low from time zero for several clock cycles, so that every register is defined before the first sampled edge. They also assume that wr_en, wr_sel and wr_data are stable around each rising edge. The bench drives all inputs only at falling edges and holds reset through the first cycles. Because the port has only one select code, it can carry at most one write per cycle. Match checks load compare first and the counter second, so the edge where the match occurs can be predicted exactly.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CAUSE   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tcu_half_rate_counter.sv
module tcu_half_rate_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o,
  output logic         changing_o
);
  logic         phase_q;
  logic [W-1:0] cnt_q;

  always_comb begin
    changing_o = load | phase_q;
    next_o     = load ? load_val : cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= load ? 1'b0 : ~phase_q;
      if (changing_o) cnt_q <= next_o;
    end
  end

  assign count_o = cnt_q;

  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)) && !phase_q);
  // R2
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !phase_q) |=> $stable(cnt_q));
  // R2
  step_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && phase_q) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/tcu_compare_match.sv
module tcu_compare_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_val,
  input  logic         cnt_changing,
  input  logic [W-1:0] cnt_next,
  output logic [W-1:0] compare_o,
  output logic         pend_o
);
  logic [W-1:0] cmp_q;
  logic         pend_q;
  logic         hit;

  assign hit = cnt_changing && (cnt_next == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_wr) cmp_q <= cmp_val;
      if (cmp_wr)   pend_q <= 1'b0;
      else if (hit) pend_q <= 1'b1;
    end
  end

  assign compare_o = cmp_q;
  assign pend_o    = pend_q;

  // R6
  cmp_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend_q);
  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cmp_wr) |=> pend_q);
  // R5
  cmp_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp_q == $past(cmp_val)));
endmodule

// File: rtl/tcu_cause_ip.sv
module tcu_cause_ip #(
  parameter int SW_N = 2,
  parameter int HW_N = 5,
  localparam int IP_N = SW_N + HW_N + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cause_wr,
  input  logic [SW_N-1:0] sw_set,
  input  logic [HW_N-1:0] hw_irq,
  input  logic            timer_pend,
  output logic [IP_N-1:0] ip_o
);
  logic [SW_N-1:0] sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sw_q <= '0;
    else if (cause_wr) sw_q <= sw_q | sw_set;
  end

  assign ip_o = {timer_pend, hw_irq, sw_q};

  // R8
  sw_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sw_q & $past(sw_q)) == $past(sw_q)));
  // R8
  sw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((sw_q & $past(sw_set)) == $past(sw_set)));
  // R8
  sw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> $stable(sw_q));
endmodule

// File: rtl/tick_compare_unit.sv
module tick_compare_unit #(
  parameter int W      = 32,
  parameter int SW_N   = 2,
  parameter int HW_N   = 5,
  parameter int IP_LSB = 8,
  localparam int IP_N  = SW_N + HW_N + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [W-1:0]    wr_data,
  input  logic [1:0]      rd_sel,
  output logic [W-1:0]    rd_data,
  input  logic [HW_N-1:0] hw_irq,
  output logic [IP_N-1:0] ip_o
);
  import tcu_pkg::*;

  reg_sel_e wsel, rsel;
  logic     wr_count, wr_cmp, wr_cause;
  logic [W-1:0] count_v, next_v, compare_v;
  logic     changing, timer_pend;

  assign wsel     = reg_sel_e'(wr_sel);
  assign rsel     = reg_sel_e'(rd_sel);
  assign wr_count = wr_en && (wsel == SEL_COUNT);
  assign wr_cmp   = wr_en && (wsel == SEL_COMPARE);
  assign wr_cause = wr_en && (wsel == SEL_CAUSE);

  tcu_half_rate_counter #(.W(W)) cnt_u (
    .clk(clk), .rst_n(rst_n), .load(wr_count), .load_val(wr_data),
    .count_o(count_v), .next_o(next_v), .changing_o(changing));

  tcu_compare_match #(.W(W)) cmp_u (
    .clk(clk), .rst_n(rst_n), .cmp_wr(wr_cmp), .cmp_val(wr_data),
    .cnt_changing(changing), .cnt_next(next_v),
    .compare_o(compare_v), .pend_o(timer_pend));

  tcu_cause_ip #(.SW_N(SW_N), .HW_N(HW_N)) cause_u (
    .clk(clk), .rst_n(rst_n), .cause_wr(wr_cause),
    .sw_set(wr_data[IP_LSB +: SW_N]), .hw_irq(hw_irq),
    .timer_pend(timer_pend), .ip_o(ip_o));

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_COUNT:   rd_data = count_v;
      SEL_COMPARE: rd_data = compare_v;
      SEL_CAUSE:   rd_data[IP_LSB +: IP_N] = ip_o;
      default:     rd_data = '0;
    endcase
  end

  // R9
  hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (ip_o[SW_N +: HW_N] == hw_irq));
endmodule

// File: tb/tick_compare_unit_tb_top.sv
module tick_compare_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [4:0]  hw_irq = '0;
  logic [7:0]  ip_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  tick_compare_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .hw_irq(hw_irq), .ip_o(ip_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 count", v, 32'd0);
    rd(2'd1, v); chk("R1 compare", v, 32'd0);
    rd(2'd2, v); chk("R1 cause", v, 32'd0);
    chk("R1 ip", {24'd0, ip_o}, 32'd0);
    step(1); rd(2'd0, v); chk("R2 first edge holds", v, 32'd0);
    step(1); rd(2'd0, v); chk("R2 second edge steps", v, 32'd1);
  endtask

  task automatic t_rate;
    logic [31:0] v;
    wr(2'd0, 32'd100);
    rd(2'd0, v); chk("R3 load", v, 32'd100);
    step(1); rd(2'd0, v); chk("R3 hold after load", v, 32'd100);
    step(1); rd(2'd0, v); chk("R3 step after load", v, 32'd101);
    step(4); rd(2'd0, v); chk("R2 half rate", v, 32'd103);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    step(2); rd(2'd0, v); chk("R4 wrap", v, 32'd0);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(2'd1, 32'd10);
    rd(2'd1, v); chk("R5 compare readback", v, 32'd10);
    chk("R6 cleared by compare write", {31'd0, ip_o[7]}, 32'd0);
    wr(2'd0, 32'd8);
    step(3); chk("R7 before match", {31'd0, ip_o[7]}, 32'd0);
    step(1); chk("R7 at match", {31'd0, ip_o[7]}, 32'd1);
    step(6); chk("R7 sticky", {31'd0, ip_o[7]}, 32'd1);
    rd(2'd2, v); chk("R10 timer in cause", v & 32'h8000, 32'h8000);
    wr(2'd1, 32'h1000);
    chk("R6 clear", {31'd0, ip_o[7]}, 32'd0);
    wr(2'd0, 32'h1000);
    chk("R7 load match", {31'd0, ip_o[7]}, 32'd1);
    wr(2'd1, 32'hFFFF_0000);
    chk("R6 clear again", {31'd0, ip_o[7]}, 32'd0);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    wr(2'd2, 32'h0000_0100);
    rd(2'd2, v); chk("R8 set sw0", v, 32'h100);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R8 zero keeps", v, 32'h100);
    wr(2'd2, 32'hFFFF_FCFF);
    rd(2'd2, v); chk("R8 other bits ignored", v, 32'h100);
    wr(2'd2, 32'h0000_0200);
    rd(2'd2, v); chk("R8 set sw1", v, 32'h300);
    chk("R8 ip sw", {24'd0, ip_o}, 32'h03);
  endtask

  task automatic t_hw;
    logic [31:0] v;
    @(negedge clk); hw_irq = 5'b10101; #1;
    chk("R9 hw on ip", {24'd0, ip_o}, 32'h57);
    rd(2'd2, v); chk("R10 cause layout", v, 32'h5700);
    @(negedge clk); hw_irq = 5'b00000; #1;
    chk("R9 hw drop", {24'd0, ip_o}, 32'h03);
  endtask

  task automatic t_none;
    logic [31:0] v;
    rd(2'd3, v); chk("R11 sel3 reads zero", v, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R11 compare untouched", v, 32'hFFFF_0000);
    rd(2'd2, v); chk("R11 cause untouched", v, 32'h300);
  endtask

  task automatic t_reset_clears;
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    step(2); rst_n = 1'b1; #1;
    rd(2'd2, v); chk("R1 sw cleared by reset", v, 32'd0);
    rd(2'd1, v); chk("R1 compare after reset", v, 32'd0);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_rate();
    t_wrap();
    t_match();
    t_soft();
    t_hw();
    t_none();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule